// File: doc/BRIEF.md
# DS0 Loopback Test Controller

This block sits on the test-set side of a 64 kbit/s channel. It puts a remote element into loopback and then measures the returned stream bit by bit against what it sent. One byte is launched and one byte is sampled on every byte strobe. Two ways of holding the far end in loopback are offered. In the latching way, a burst of loopback code bytes is sent, the block waits for the far end to answer with a run of confirmation bytes, and then fills every byte with test data until it is told to stop, at which point it sends a release sequence. In the alternating way, code bytes and test-data bytes take turns, and only the data bytes are checked.

The expected value of each received byte is the byte launched a run-time number of strobes earlier, held in a short history line together with a flag that marks it as a test-data byte. Bit errors and compared bits accumulate in two 32-bit counters that are cleared when a test starts. If the far end does not confirm in time, the block stops in a failed state until it is started again.

Top module: `lbt_ctrl`

## Requirements
- R1: After start in latching mode the block launches `lb_code_i` on exactly `send_cnt_i` consecutive strobes (`send_cnt_i` >= 1), then launches the idle fill byte 0xFF while it waits for confirmation.
- R2: While waiting, loopback counts as established (`latched_o` high, `state_o` = 3) at the strobe that samples the `conf_thr_i`-th consecutive `rx_byte_i` equal to `conf_byte_i`; any other byte restarts the run.
- R3: If `timeout_i` strobes pass while waiting without the loopback being established, `state_o` becomes 6 and `fail_o` rises; it stays there, launching 0xFF, until `start_i`.
- R4: While latched, every strobe launches `data_i` and raises `data_req_o`; at each strobe whose expected byte is a test-data byte, `bit_cnt_o` grows by 8 and `bit_err_o` grows by the number of differing bits.
- R5: `stop_i` during the latched test moves to the release state (`state_o` = 4), which launches `rel_byte_i` on exactly `rel_cnt_i` strobes and then returns to idle (`state_o` = 0, fill 0xFF).
- R6: In alternating mode (`state_o` = 5) launches alternate strictly between `lb_code_i` and `data_i`, beginning with the code byte; `stop_i` returns to idle.
- R7: In alternating mode only data-slot bytes are compared; bit errors in the returned copies of code bytes change neither counter.
- R8: `start_i` from idle or the failed state clears both counters and discards all in-flight comparisons.
- R9: After reset the block is idle (`state_o` = 0), launches 0xFF, holds `latched_o`, `fail_o` and `data_req_o` low and both counters at zero.
- R10: The byte compared at a strobe is the byte launched `rt_delay_i` strobes earlier, for any delay from 1 to the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a test (from idle or failed) |
| stop_i | input | 1 | End the running test |
| alt_mode_i | input | 1 | 1 = alternating mode, 0 = latching mode |
| byte_stb_i | input | 1 | One-cycle strobe per DS0 byte time |
| lb_code_i | input | 8 | Loopback code byte |
| conf_byte_i | input | 8 | Expected confirmation byte |
| rel_byte_i | input | 8 | Release byte |
| send_cnt_i | input | 16 | Code burst length in bytes |
| conf_thr_i | input | 16 | Consecutive confirmation bytes required |
| rel_cnt_i | input | 16 | Release sequence length in bytes |
| timeout_i | input | 16 | Wait limit in bytes after the burst |
| rt_delay_i | input | 4 | Round-trip delay in bytes (1..8) |
| data_i | input | 8 | Test-data byte, taken when data_req_o is high at a strobe |
| rx_byte_i | input | 8 | Received byte, sampled at each strobe |
| tx_byte_o | output | 8 | Byte launched at the last strobe |
| data_req_o | output | 1 | The next strobe launches a test-data byte |
| state_o | output | 3 | 0 idle, 1 code, 2 wait, 3 test, 4 release, 5 alternating, 6 failed |
| latched_o | output | 1 | Latched loopback established and testing |
| fail_o | output | 1 | Confirmation timed out |
| bit_err_o | output | 32 | Bit errors counted |
| bit_cnt_o | output | 32 | Bits compared |

## Verification
The assertions watch, at every strobe, that the launched byte matches the source the current state selects (code, data, release), that alternating launches really alternate, that latching is only entered from the wait state, that the failed state holds, that counters move only on strobes, never show more errors than bits, and clear on start. Burst and release lengths, the exact confirmation-run and timeout boundaries, the delay alignment and the exclusion of code-slot errors depend on counting across many strobes, so only the bench scenarios, swept over several round-trip delays with error masks on chosen slots, show them.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CODE = 3'd1,
    ST_WAIT = 3'd2,
    ST_TEST = 3'd3,
    ST_REL  = 3'd4,
    ST_ALT  = 3'd5,
    ST_FAIL = 3'd6
  } lbt_state_e;

  localparam logic [7:0] IDLE_FILL = 8'hFF;
endpackage

// File: rtl/lbt_fsm.sv
module lbt_fsm
  import lbt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          alt_mode_i,
  input  logic          stb_i,
  input  logic [7:0]    lb_code_i,
  input  logic [7:0]    conf_byte_i,
  input  logic [7:0]    rel_byte_i,
  input  logic [CW-1:0] send_cnt_i,
  input  logic [CW-1:0] conf_thr_i,
  input  logic [CW-1:0] rel_cnt_i,
  input  logic [CW-1:0] timeout_i,
  input  logic [7:0]    data_i,
  input  logic [7:0]    rx_byte_i,
  output lbt_state_e    state_o,
  output logic [7:0]    launch_o,
  output logic          launch_dat_o,
  output logic          clr_o
);
  lbt_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] run_q;
  logic          phase_q;
  logic          conf_hit;
  logic          established;

  assign clr_o       = start_i && (state_q == ST_IDLE || state_q == ST_FAIL);
  assign conf_hit    = (rx_byte_i == conf_byte_i);
  assign established = conf_hit && (run_q + 1'b1 == conf_thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      run_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_FAIL: begin
          if (start_i) begin
            state_q <= alt_mode_i ? ST_ALT : ST_CODE;
            cnt_q   <= '0;
            run_q   <= '0;
            phase_q <= 1'b0;
          end
        end
        ST_CODE: begin
          if (stb_i) begin
            if (cnt_q + 1'b1 >= send_cnt_i) begin
              state_q <= ST_WAIT;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (stb_i) begin
            run_q <= conf_hit ? run_q + 1'b1 : '0;
            if (established) begin
              state_q <= ST_TEST;
            end else if (cnt_q + 1'b1 == timeout_i) begin
              state_q <= ST_FAIL;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_TEST: begin
          if (stop_i) begin
            state_q <= ST_REL;
            cnt_q   <= '0;
          end
        end
        ST_REL: begin
          if (stb_i) begin
            if (cnt_q + 1'b1 >= rel_cnt_i) begin
              state_q <= ST_IDLE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_ALT: begin
          if (stop_i) state_q <= ST_IDLE;
          else if (stb_i) phase_q <= ~phase_q;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    launch_o     = IDLE_FILL;
    launch_dat_o = 1'b0;
    unique case (state_q)
      ST_CODE: launch_o = lb_code_i;
      ST_TEST: begin
        launch_o     = data_i;
        launch_dat_o = 1'b1;
      end
      ST_REL:  launch_o = rel_byte_i;
      ST_ALT: begin
        launch_o     = phase_q ? data_i : lb_code_i;
        launch_dat_o = phase_q;
      end
      default: launch_o = IDLE_FILL;
    endcase
  end

  assign state_o = state_q;
endmodule

// File: rtl/lbt_hist.sv
module lbt_hist
  import lbt_pkg::*;
#(
  parameter int MAX_DLY = 8,
  localparam int DW = $clog2(MAX_DLY + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic          clr_i,
  input  logic [7:0]    push_byte_i,
  input  logic          push_dat_i,
  input  logic [DW-1:0] dly_i,
  output logic [7:0]    head_o,
  output logic [7:0]    exp_byte_o,
  output logic          exp_dat_o
);
  logic [7:0]         byt_q [MAX_DLY];
  logic [MAX_DLY-1:0] dat_q;
  logic [DW-1:0]      idx;

  always_comb begin
    if (dly_i == '0)                   idx = '0;
    else if (dly_i > DW'(MAX_DLY))     idx = DW'(MAX_DLY - 1);
    else                               idx = dly_i - 1'b1;
  end

  for (genvar g = 0; g < MAX_DLY; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byt_q[g] <= IDLE_FILL;
        dat_q[g] <= 1'b0;
      end else if (clr_i) begin
        dat_q[g] <= 1'b0;
      end else if (stb_i) begin
        if (g == 0) begin
          byt_q[g] <= push_byte_i;
          dat_q[g] <= push_dat_i;
        end else begin
          byt_q[g] <= byt_q[(g == 0) ? 0 : g-1];
          dat_q[g] <= dat_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  end

  assign head_o     = byt_q[0];
  assign exp_byte_o = byt_q[idx];
  assign exp_dat_o  = dat_q[idx];
endmodule

// File: rtl/lbt_errcnt.sv
module lbt_errcnt #(
  parameter int NW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          cmp_i,
  input  logic [7:0]    rx_i,
  input  logic [7:0]    exp_i,
  output logic [NW-1:0] err_o,
  output logic [NW-1:0] cnt_o
);
  logic [7:0] diff;
  logic [3:0] ones;

  assign diff = rx_i ^ exp_i;

  always_comb begin
    ones = '0;
    for (int i = 0; i < 8; i++) ones = ones + {3'b000, diff[i]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o <= '0;
      cnt_o <= '0;
    end else if (clr_i) begin
      err_o <= '0;
      cnt_o <= '0;
    end else if (cmp_i) begin
      err_o <= err_o + NW'(ones);
      cnt_o <= cnt_o + NW'(8);
    end
  end
endmodule

// File: rtl/lbt_ctrl.sv
module lbt_ctrl
  import lbt_pkg::*;
#(
  parameter int CW      = 16,
  parameter int MAX_DLY = 8,
  parameter int NW      = 32,
  localparam int DW = $clog2(MAX_DLY + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          alt_mode_i,
  input  logic          byte_stb_i,
  input  logic [7:0]    lb_code_i,
  input  logic [7:0]    conf_byte_i,
  input  logic [7:0]    rel_byte_i,
  input  logic [CW-1:0] send_cnt_i,
  input  logic [CW-1:0] conf_thr_i,
  input  logic [CW-1:0] rel_cnt_i,
  input  logic [CW-1:0] timeout_i,
  input  logic [DW-1:0] rt_delay_i,
  input  logic [7:0]    data_i,
  input  logic [7:0]    rx_byte_i,
  output logic [7:0]    tx_byte_o,
  output logic          data_req_o,
  output logic [2:0]    state_o,
  output logic          latched_o,
  output logic          fail_o,
  output logic [NW-1:0] bit_err_o,
  output logic [NW-1:0] bit_cnt_o
);
  lbt_state_e state;
  logic [7:0] launch;
  logic       launch_dat;
  logic       clr;
  logic [7:0] exp_byte;
  logic       exp_dat;

  lbt_fsm #(.CW(CW)) u_fsm (
    .clk_i, .rst_ni, .start_i, .stop_i, .alt_mode_i,
    .stb_i       (byte_stb_i),
    .lb_code_i, .conf_byte_i, .rel_byte_i,
    .send_cnt_i, .conf_thr_i, .rel_cnt_i, .timeout_i,
    .data_i, .rx_byte_i,
    .state_o     (state),
    .launch_o    (launch),
    .launch_dat_o(launch_dat),
    .clr_o       (clr)
  );

  lbt_hist #(.MAX_DLY(MAX_DLY)) u_hist (
    .clk_i, .rst_ni,
    .stb_i      (byte_stb_i),
    .clr_i      (clr),
    .push_byte_i(launch),
    .push_dat_i (launch_dat),
    .dly_i      (rt_delay_i),
    .head_o     (tx_byte_o),
    .exp_byte_o (exp_byte),
    .exp_dat_o  (exp_dat)
  );

  lbt_errcnt #(.NW(NW)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i(clr),
    .cmp_i(byte_stb_i && exp_dat),
    .rx_i (rx_byte_i),
    .exp_i(exp_byte),
    .err_o(bit_err_o),
    .cnt_o(bit_cnt_o)
  );

  assign data_req_o = launch_dat;
  assign state_o    = state;
  assign latched_o  = (state == ST_TEST);
  assign fail_o     = (state == ST_FAIL);
endmodule

// File: rtl/lbt_chk.sv
module lbt_chk #(
  parameter int NW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          stop_i,
  input logic          byte_stb_i,
  input logic [7:0]    lb_code_i,
  input logic [7:0]    rel_byte_i,
  input logic [7:0]    data_i,
  input logic [7:0]    tx_byte_o,
  input logic          data_req_o,
  input logic [2:0]    state_o,
  input logic          latched_o,
  input logic          fail_o,
  input logic [NW-1:0] bit_err_o,
  input logic [NW-1:0] bit_cnt_o
);
  p_code_launch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb_i && state_o == 3'd1 |=> tx_byte_o == $past(lb_code_i));

  p_latch_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latched_o) |-> $past(state_o) == 3'd2);

  p_fail_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !start_i |=> fail_o);

  p_data_launch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb_i && data_req_o |=> tx_byte_o == $past(data_i));

  p_err_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_err_o <= bit_cnt_o);

  p_cnt_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_stb_i && !start_i |=> $stable(bit_cnt_o) && $stable(bit_err_o));

  p_rel_launch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb_i && state_o == 3'd4 |=> tx_byte_o == $past(rel_byte_i));

  p_alt_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb_i && state_o == 3'd5 && !data_req_o |=> tx_byte_o == $past(lb_code_i));

  p_alt_to_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb_i && state_o == 3'd5 && !data_req_o && !stop_i |=> data_req_o);

  p_alt_to_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb_i && state_o == 3'd5 && data_req_o && !stop_i |=> !data_req_o);

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (state_o == 3'd0 || state_o == 3'd6) |=> bit_cnt_o == '0 && bit_err_o == '0);
endmodule

bind lbt_ctrl lbt_chk #(.NW(NW)) u_chk (.*);

// File: tb/lbt_ctrl_tb.sv
module lbt_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, alt_mode_i = 1'b0, byte_stb_i = 1'b0;
  logic [7:0]  lb_code_i = 8'hA5, conf_byte_i = 8'h3C, rel_byte_i = 8'h5A;
  logic [15:0] send_cnt_i = 16'd5, conf_thr_i = 16'd3, rel_cnt_i = 16'd4, timeout_i = 16'd20;
  logic [3:0]  rt_delay_i = 4'd1;
  logic [7:0]  data_i = 8'h11, rx_byte_i = 8'h00;
  logic [7:0]  tx_byte_o;
  logic        data_req_o, latched_o, fail_o;
  logic [2:0]  state_o;
  logic [31:0] bit_err_o, bit_cnt_o;

  int checks = 0, errors = 0;
  logic [7:0] bhist [8];
  logic [7:0] bdat;
  int exp_cnt, exp_err, dly;

  lbt_ctrl u_dut (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one byte time; use_lb: return launched byte delayed by dly, xor val
  task automatic tick(input bit use_lb, input logic [7:0] val);
    logic d;
    rx_byte_i = use_lb ? (bhist[dly-1] ^ val) : val;
    d = data_req_o;
    if (bdat[dly-1]) begin
      exp_cnt += 8;
      exp_err += $countones(rx_byte_i ^ bhist[dly-1]);
    end
    @(negedge clk_i) byte_stb_i = 1'b1;
    @(negedge clk_i) byte_stb_i = 1'b0;
    for (int i = 7; i > 0; i--) begin
      bhist[i] = bhist[i-1];
      bdat[i]  = bdat[i-1];
    end
    bhist[0] = tx_byte_o;
    bdat[0]  = d;
    data_i   = data_i * 8'd29 + 8'd7;
  endtask

  task automatic pulse_start(input bit alt);
    alt_mode_i = alt;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    bdat = '0;
    exp_cnt = 0;
    exp_err = 0;
    chk(bit_cnt_o == 0 && bit_err_o == 0, "R8", bit_cnt_o, 0);
  endtask

  task automatic pulse_stop();
    @(negedge clk_i) stop_i = 1'b1;
    @(negedge clk_i) stop_i = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) bhist[i] = 8'hFF;
    bdat = '0;
    dly = 1;
    exp_cnt = 0;
    exp_err = 0;
    repeat (3) @(negedge clk_i);
    chk(state_o == 0 && tx_byte_o == 8'hFF && !latched_o && !fail_o && !data_req_o
        && bit_cnt_o == 0 && bit_err_o == 0, "R9", {state_o, tx_byte_o}, 12'h0FF);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // latching mode, swept over round-trip delays
    for (int d = 1; d <= 4; d++) begin
      dly = d;
      rt_delay_i = 4'(d);
      pulse_start(1'b0);
      for (int k = 0; k < 5; k++) begin
        tick(1'b0, 8'h00);
        chk(tx_byte_o == lb_code_i, "R1", tx_byte_o, lb_code_i);
      end
      tick(1'b0, 8'h00);
      chk(tx_byte_o == 8'hFF && state_o == 2, "R1", tx_byte_o, 8'hFF);
      tick(1'b0, conf_byte_i);
      tick(1'b0, conf_byte_i);
      tick(1'b0, 8'h00);
      chk(!latched_o, "R2", latched_o, 0);
      tick(1'b0, conf_byte_i);
      tick(1'b0, conf_byte_i);
      chk(!latched_o, "R2", latched_o, 0);
      tick(1'b0, conf_byte_i);
      chk(latched_o && state_o == 3 && data_req_o, "R2", state_o, 3);
      for (int k = 0; k < 12; k++) begin
        tick(1'b1, (k % 3 == 1) ? 8'h05 : 8'h00);
        chk(bdat[0] == 1'b1, "R4", bdat[0], 1);
      end
      pulse_stop();
      chk(state_o == 4, "R5", state_o, 4);
      for (int k = 0; k < 4; k++) begin
        tick(1'b1, 8'h80);
        chk(tx_byte_o == rel_byte_i, "R5", tx_byte_o, rel_byte_i);
      end
      chk(state_o == 0, "R5", state_o, 0);
      for (int k = 0; k < 4; k++) tick(1'b1, 8'h00);
      chk(tx_byte_o == 8'hFF, "R5", tx_byte_o, 8'hFF);
      chk(bit_cnt_o == 32'(exp_cnt), "R10", bit_cnt_o, exp_cnt);
      chk(bit_err_o == 32'(exp_err), "R4", bit_err_o, exp_err);
    end

    // timeout boundary
    dly = 1;
    rt_delay_i = 4'd1;
    timeout_i = 16'd6;
    pulse_start(1'b0);
    for (int k = 0; k < 5; k++) tick(1'b0, 8'h00);
    for (int k = 0; k < 5; k++) tick(1'b0, (k == 4) ? conf_byte_i : 8'h00);
    chk(!fail_o && state_o == 2, "R3", state_o, 2);
    tick(1'b0, conf_byte_i);
    chk(fail_o && state_o == 6, "R3", state_o, 6);
    for (int k = 0; k < 4; k++) tick(1'b0, conf_byte_i);
    pulse_stop();
    chk(fail_o && tx_byte_o == 8'hFF, "R3", tx_byte_o, 8'hFF);
    timeout_i = 16'd20;

    // alternating mode: errors only on code echoes, then only on data echoes
    for (int d = 1; d <= 4; d++) begin
      dly = d;
      rt_delay_i = 4'(d);
      for (int pass = 0; pass < 2; pass++) begin
        pulse_start(1'b1);
        chk(state_o == 5, "R6", state_o, 5);
        for (int k = 0; k < 16; k++) begin
          if (pass == 0) tick(1'b1, bdat[dly-1] ? 8'h00 : 8'hFF);
          else           tick(1'b1, bdat[dly-1] ? 8'h81 : 8'h00);
          chk(bdat[0] == k[0], "R6", bdat[0], k[0]);
          if (!k[0]) chk(tx_byte_o == lb_code_i, "R6", tx_byte_o, lb_code_i);
        end
        pulse_stop();
        chk(state_o == 0, "R6", state_o, 0);
        for (int k = 0; k < 4; k++) tick(1'b1, 8'h00);
        chk(bit_cnt_o == 32'(exp_cnt), "R7", bit_cnt_o, exp_cnt);
        chk(bit_err_o == 32'(exp_err), "R7", bit_err_o, exp_err);
        if (pass == 0) chk(bit_err_o == 0, "R7", bit_err_o, 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule